// File: doc/BRIEF.md
# Level-Encoded Dual-Rail Link Codec

This block pairs a sender and a receiver for a word-wide link in which every bit travels on two wires: a value wire and a phase wire. Transfers use two-phase (transition) signalling with no return-to-zero step. For each new word the sender moves exactly one wire per bit. If the bit's value changed, the value wire moves. If the value is unchanged, the phase wire moves. The value wire therefore always carries the bit itself, and the XOR of the two wires gives a per-bit parity that alternates from one word to the next.

The receiver keeps the parity it expects next. It waits until every bit shows that parity, then presents the decoded word with a one-cycle strobe, inverts its expected parity and toggles its acknowledge wire. The sender holds a busy flag from the moment it accepts a word until it sees that acknowledge toggle. A request made while busy is stalled: the word is not taken and the wires do not move. The wires between the two halves leave the block at its ports, so the surrounding logic (or a bench) can deliver each bit with its own delay.

Top module: `lenc_dual_rail_codec`

## Requirements
- R1: After reset, all sender wires, busy, the receiver strobe and the acknowledge output are low, and the receiver expects parity 1 (value XOR phase) for the first word.
- R2: On an accepted word, each bit whose value differs from the previous word toggles its value wire only, and the value wire then equals the bit.
- R3: On an accepted word, each bit whose value equals the previous word toggles its phase wire only.
- R4: A word is accepted on a clock edge where the send request is high and busy is low; busy is high from the next cycle.
- R5: A send request while busy is ignored: the sender wires and busy are unchanged in the next cycle.
- R6: The receiver strobe stays low while any bit's value XOR phase differs from the expected parity, and rises in the cycle after the last bit matches.
- R7: The strobe lasts one cycle, and with it the output word equals the value wires seen at completion.
- R8: The acknowledge output toggles once for each completed word and at no other time, and the expected parity inverts, so consecutive identical words, which move only phase wires, still complete.
- R9: Busy stays high until the acknowledge input differs from its last seen level, and clears in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_valid | input | 1 | Send request |
| snd_word | input | WIDTH | Single-rail word to send |
| busy | output | 1 | Sender waiting for acknowledge |
| tx_val | output | WIDTH | Sender value wires |
| tx_par | output | WIDTH | Sender phase wires |
| tx_ack_in | input | 1 | Acknowledge toggle seen by the sender |
| rx_val | input | WIDTH | Value wires arriving at the receiver |
| rx_par | input | WIDTH | Phase wires arriving at the receiver |
| rx_word | output | WIDTH | Decoded word |
| rx_strobe | output | 1 | One-cycle word-valid strobe |
| rx_ack_out | output | 1 | Acknowledge toggle from the receiver |

## Verification
The bench delivers the bits of each word to the receiver in random, unequal cycles. It checks that no strobe appears before the last bit lands; a receiver that tested only some bits would strobe early. Runs of identical words are sent. In those transfers only phase wires move, so a receiver keyed on value changes, or one that never flips its expected parity, would hang or strobe at once. Requests are also made while busy, so a sender that forgot to stall would move wires mid-transfer, and busy is watched on both sides of the acknowledge toggle.

// File: rtl/lenc_pkg.sv
package lenc_pkg;
   // Phase wire level after a transfer: it moves only when the value holds.
   function automatic logic next_phase(input logic old_val,
                                       input logic new_val,
                                       input logic old_phase);
      return (old_val == new_val) ? ~old_phase : old_phase;
   endfunction
endpackage

// File: rtl/lenc_tx_bit.sv
module lenc_tx_bit
   import lenc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic new_bit,
   output logic line_val,
   output logic line_par
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_val <= 1'b0;
         line_par <= 1'b0;
      end else if (load) begin
         line_par <= next_phase(line_val, new_bit, line_par);
         line_val <= new_bit;
      end
   end
endmodule

// File: rtl/lenc_tx.sv
module lenc_tx #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             snd_valid,
   input  logic [WIDTH-1:0] snd_word,
   input  logic             ack_in,
   output logic             busy,
   output logic [WIDTH-1:0] tx_val,
   output logic [WIDTH-1:0] tx_par
);
   logic pending;
   logic ack_seen;
   logic load;
   logic ack_edge;

   assign load     = snd_valid & ~pending;
   assign ack_edge = ack_in ^ ack_seen;
   assign busy     = pending;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending  <= 1'b0;
         ack_seen <= 1'b0;
      end else begin
         ack_seen <= ack_in;
         if (load)          pending <= 1'b1;
         else if (ack_edge) pending <= 1'b0;
      end
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      lenc_tx_bit u_bit (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (load),
         .new_bit  (snd_word[i]),
         .line_val (tx_val[i]),
         .line_par (tx_par[i])
      );
   end
endmodule

// File: rtl/lenc_rx.sv
module lenc_rx #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] rx_val,
   input  logic [WIDTH-1:0] rx_par,
   output logic [WIDTH-1:0] rx_word,
   output logic             rx_strobe,
   output logic             ack_out
);
   logic             exp_par;
   logic [WIDTH-1:0] bit_ok;
   logic             done;

   for (genvar i = 0; i < WIDTH; i++) begin : g_cmp
      assign bit_ok[i] = ((rx_val[i] ^ rx_par[i]) == exp_par);
   end
   assign done = &bit_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exp_par   <= 1'b1;
         rx_word   <= '0;
         rx_strobe <= 1'b0;
         ack_out   <= 1'b0;
      end else begin
         rx_strobe <= done;
         if (done) begin
            rx_word <= rx_val;
            exp_par <= ~exp_par;
            ack_out <= ~ack_out;
         end
      end
   end
endmodule

// File: rtl/lenc_dual_rail_codec.sv
module lenc_dual_rail_codec #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             snd_valid,
   input  logic [WIDTH-1:0] snd_word,
   output logic             busy,
   output logic [WIDTH-1:0] tx_val,
   output logic [WIDTH-1:0] tx_par,
   input  logic             tx_ack_in,
   input  logic [WIDTH-1:0] rx_val,
   input  logic [WIDTH-1:0] rx_par,
   output logic [WIDTH-1:0] rx_word,
   output logic             rx_strobe,
   output logic             rx_ack_out
);
   if (WIDTH < 1) begin : g_bad_width
      $error("lenc_dual_rail_codec: WIDTH must be at least 1");
   end

   lenc_tx #(.WIDTH(WIDTH)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .snd_valid (snd_valid),
      .snd_word  (snd_word),
      .ack_in    (tx_ack_in),
      .busy      (busy),
      .tx_val    (tx_val),
      .tx_par    (tx_par)
   );

   lenc_rx #(.WIDTH(WIDTH)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_val    (rx_val),
      .rx_par    (rx_par),
      .rx_word   (rx_word),
      .rx_strobe (rx_strobe),
      .ack_out   (rx_ack_out)
   );
endmodule

// File: rtl/lenc_codec_chk.sv
module lenc_codec_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             snd_valid,
   input logic [WIDTH-1:0] snd_word,
   input logic             busy,
   input logic [WIDTH-1:0] tx_val,
   input logic [WIDTH-1:0] tx_par,
   input logic [WIDTH-1:0] rx_val,
   input logic [WIDTH-1:0] rx_word,
   input logic             rx_strobe,
   input logic             rx_ack_out
);
   // R2 R3
   one_wire_per_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_valid && !busy) |=>
         ((((tx_val ^ $past(tx_val)) ^ (tx_par ^ $past(tx_par))) == {WIDTH{1'b1}}) &&
          (((tx_val ^ $past(tx_val)) & (tx_par ^ $past(tx_par))) == {WIDTH{1'b0}})));

   // R2
   value_follows_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_valid && !busy) |=> (tx_val == $past(snd_word)));

   // R4
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_valid && !busy) |=> busy);

   // R5
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_valid && busy) |=> ($stable(tx_val) && $stable(tx_par)));

   // R7
   word_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe |-> (rx_word == $past(rx_val)));

   // R8
   ack_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe |-> (rx_ack_out != $past(rx_ack_out)));

   // R8
   ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_strobe |-> $stable(rx_ack_out));
endmodule

bind lenc_dual_rail_codec lenc_codec_chk #(.WIDTH(WIDTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .snd_valid  (snd_valid),
   .snd_word   (snd_word),
   .busy       (busy),
   .tx_val     (tx_val),
   .tx_par     (tx_par),
   .rx_val     (rx_val),
   .rx_word    (rx_word),
   .rx_strobe  (rx_strobe),
   .rx_ack_out (rx_ack_out)
);

// File: tb/test_lenc_dual_rail_codec.sv
module test_lenc_dual_rail_codec;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         snd_valid;
   logic [W-1:0] snd_word;
   logic         busy;
   logic [W-1:0] tx_val, tx_par;
   logic         tx_ack_in;
   logic [W-1:0] rx_val, rx_par;
   logic [W-1:0] rx_word;
   logic         rx_strobe;
   logic         rx_ack_out;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [W-1:0] m_val, m_par;
   logic         m_ack;

   always #4 clk = ~clk;

   lenc_dual_rail_codec #(.WIDTH(W)) i_lenc_dual_rail_codec (
      .clk(clk), .rst_n(rst_n), .snd_valid(snd_valid), .snd_word(snd_word),
      .busy(busy), .tx_val(tx_val), .tx_par(tx_par), .tx_ack_in(tx_ack_in),
      .rx_val(rx_val), .rx_par(rx_par), .rx_word(rx_word),
      .rx_strobe(rx_strobe), .rx_ack_out(rx_ack_out)
   );

   task automatic chk(input bit ok, input string req,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Expected phase wires after sending w: phase moves where the value holds.
   function automatic logic [W-1:0] exp_phase(input logic [W-1:0] old_v,
                                              input logic [W-1:0] old_p,
                                              input logic [W-1:0] w);
      return old_p ^ ~(old_v ^ w);
   endfunction

   task automatic send(input logic [W-1:0] w, input int skew, input bit stall);
      int d [W];
      int maxd = 0;
      snd_word  = w;
      snd_valid = 1'b1;
      @(negedge clk);
      snd_valid = 1'b0;
      m_par = exp_phase(m_val, m_par, w);
      m_val = w;
      chk(busy == 1'b1, "R4 busy after accept", busy, 1);
      chk(tx_val == m_val, "R2 value wires", tx_val, m_val);
      chk(tx_par == m_par, "R3 phase wires", tx_par, m_par);
      if (stall) begin
         snd_word  = ~w;
         snd_valid = 1'b1;
         @(negedge clk);
         snd_valid = 1'b0;
         chk({tx_val, tx_par} == {m_val, m_par}, "R5 wires held while busy",
             {tx_val, tx_par}, {m_val, m_par});
         chk(busy == 1'b1, "R5 busy held", busy, 1);
      end
      for (int i = 0; i < W; i++) begin
         d[i] = $urandom_range(skew, 0);
         if (d[i] > maxd) maxd = d[i];
      end
      for (int c = 0; c <= maxd; c++) begin
         for (int i = 0; i < W; i++) begin
            if (d[i] == c) begin
               rx_val[i] = tx_val[i];
               rx_par[i] = tx_par[i];
            end
         end
         @(negedge clk);
         if (c < maxd) begin
            chk(rx_strobe == 1'b0, "R6 no strobe with lagging bits", rx_strobe, 0);
         end else begin
            m_ack = ~m_ack;
            chk(rx_strobe == 1'b1, "R6 strobe after last bit", rx_strobe, 1);
            chk(rx_word == w, "R7 decoded word", rx_word, w);
            chk(rx_ack_out == m_ack, "R8 ack toggled", rx_ack_out, m_ack);
         end
      end
      @(negedge clk);
      chk(rx_strobe == 1'b0, "R7 strobe one cycle", rx_strobe, 0);
      chk(rx_ack_out == m_ack, "R8 ack steady", rx_ack_out, m_ack);
      chk(busy == 1'b1, "R9 busy until ack seen", busy, 1);
      tx_ack_in = rx_ack_out;
      @(negedge clk);
      chk(busy == 1'b0, "R9 busy cleared", busy, 0);
   endtask

   initial begin
      void'($urandom(32'd2024));
      rst_n = 1'b0; snd_valid = 1'b0; snd_word = '0;
      tx_ack_in = 1'b0; rx_val = '0; rx_par = '0;
      m_val = '0; m_par = '0; m_ack = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk({tx_val, tx_par} == '0, "R1 wires low", {tx_val, tx_par}, 0);
      chk(busy == 1'b0, "R1 busy low", busy, 0);
      chk(rx_strobe == 1'b0 && rx_ack_out == 1'b0, "R1 rx idle",
          {rx_strobe, rx_ack_out}, 0);
      // R1: all-zero first word moves only phase wires to reach parity 1
      send('0, 0, 1'b0);
      // R8: repeated identical words, phase wires only
      send('0, 3, 1'b1);
      send('0, 2, 1'b0);
      send('1, 4, 1'b1);
      send('1, 1, 1'b0);
      send('1, 0, 1'b0);
      send(W'(8'h5A), 5, 1'b1);
      send(W'(8'hA5), 5, 1'b0);
      for (int n = 0; n < 40; n++) begin
         send(W'($urandom), int'($urandom_range(5, 0)), bit'($urandom_range(1, 0)));
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule